// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Bank

This block holds a small bank of interrupt mask and priority registers behind a 32-bit read/write port. A register can have two aliases. Writing its set alias turns on the written bits. Writing its clear alias turns off the written bits. Either operation changes only the bits that were written, so no read-modify-write sequence is needed. A register with only one alias takes the written data as its new value.

Each register is split into fields. Mask registers use 1-bit fields. Priority registers use fields of a configured width. After every accepted write, the old and new contents are compared field by field. Each field whose value changed, and which is mapped to a real interrupt source, raises a one-cycle strobe on an output lane. The lane carries the source identifier and an enable flag. The enable flag is set when the new field value is non-zero.

Everything is set by parameters: the register addresses, the field width of each register and the table that maps fields to source identifiers. The default configuration has four 8-bit registers:

- Register 0 has set alias 0x100 and clear alias 0x104, with 1-bit fields.
- Register 1 has set alias 0x108 and clear alias 0x10C, with 1-bit fields.
- Register 2 has a single address, 0x110, and 4-bit fields.
- Register 3 has set alias 0x118 and clear alias 0x11C, with 2-bit fields.

An address parameter of zero means the register has no such alias.

Top module: `mbank_top`

## Requirements
- R1: Addresses are matched on bits 28:0 only. Bus address bits 31:29 are ignored, so 0xE0000100 reaches the same alias as 0x100.
- R2: A write to a set alias of a register that also has a clear alias stores the old value OR the low 8 data bits.
- R3: A write to a clear alias stores the old value AND NOT the low 8 data bits.
- R4: A write to a register with a set address and no clear address stores the low 8 data bits directly.
- R5: A read with rd_en high returns the stored value, zero-extended, on rdata in the cycle after the request. Both aliases return the same value. An address that matches no alias returns zero.
- R6: Writes to unmapped addresses change no register and emit no strobe. Register contents never change in a cycle that follows one without wr_en.
- R7: A register with field width W has 8/W fields. Lane k carries the k-th field counted from the most significant end, so lane 0 covers bits 7:8-W. With the default table, lane k of register r reports source 8r+k, or source 0 when 8r+k is a multiple of 7.
- R8: A lane strobes only when its field's old and new values differ. Its enable bit is 1 when the new field value is non-zero and 0 when it is zero.
- R9: A field mapped to source 0 never strobes.
- R10: Strobes appear in the single cycle right after the write and are low in the next cycle unless another write occurs.
- R11: After reset, all registers, rdata and all strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request for the current cycle |
| rd_en | input | 1 | Read request for the current cycle |
| addr | input | 32 | Bus address; bits 28:0 are decoded |
| wdata | input | 32 | Write data; the low 8 bits are used |
| rdata | output | 32 | Read data, one cycle after rd_en |
| ev_vld | output | 8 | Per-lane change strobe |
| ev_en | output | 8 | Per-lane enable (1) or disable (0) |
| ev_src | output | 40 | Per-lane source identifier, 5 bits per lane, lane k at bits 5k+4:5k |

## Verification
The bench sweeps every 8-bit data value through each alias of each register and tracks the expected contents with its own arithmetic model. Set and clear writes are interleaved so that a design which swapped them, or wrote the data straight into a dual-alias register, would diverge at once. Expected strobes come from the field layout. Reversed lane order or a wrong field width would show up on the first changed priority field. A design that compared whole registers instead of single fields would strobe unchanged lanes. A design that skipped the reserved-source filter would strobe lanes mapped to source 0. The bench also accesses registers through aliases with the top address bits set, writes to unmapped addresses and checks that the strobes drop after one cycle. These catch a full-width address comparator, writes leaking into the bank and strobes that stay high.

// File: rtl/mbank_pkg.sv
package mbank_pkg;

    localparam int unsigned BANK_REGS  = 4;
    localparam int unsigned BANK_REG_W = 8;
    localparam int unsigned BANK_SRC_W = 5;

    typedef enum logic [1:0] {
        WOP_NONE   = 2'd0,
        WOP_SET    = 2'd1,
        WOP_CLR    = 2'd2,
        WOP_DIRECT = 2'd3
    } wop_e;

    // Default field-to-source table: lane k of register r -> 8r+k,
    // reserved (0) whenever that number is a multiple of 7.
    function automatic logic [BANK_REGS*BANK_REG_W*BANK_SRC_W-1:0] default_map();
        logic [BANK_REGS*BANK_REG_W*BANK_SRC_W-1:0] m;
        int unsigned id;
        m = '0;
        for (int r = 0; r < BANK_REGS; r++) begin
            for (int k = 0; k < BANK_REG_W; k++) begin
                id = r * BANK_REG_W + k;
                if (id % 7 == 0) id = 0;
                m[(r*BANK_REG_W + k)*BANK_SRC_W +: BANK_SRC_W] = id[BANK_SRC_W-1:0];
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/mbank_decode.sv
module mbank_decode
    import mbank_pkg::*;
#(
    parameter int unsigned N_REGS  = 4,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned MATCH_W = 29,
    parameter logic [N_REGS*ADDR_W-1:0] SET_ADDR = '0,
    parameter logic [N_REGS*ADDR_W-1:0] CLR_ADDR = '0,
    localparam int unsigned IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output wop_e              op
);

    logic [N_REGS-1:0] set_hit;
    logic [N_REGS-1:0] clr_hit;
    logic [N_REGS-1:0] dual;
    logic              unused_hi;

    assign unused_hi = ^addr[ADDR_W-1:MATCH_W];

    for (genvar r = 0; r < N_REGS; r++) begin : g_match
        localparam logic [ADDR_W-1:0] SA = SET_ADDR[r*ADDR_W +: ADDR_W];
        localparam logic [ADDR_W-1:0] CA = CLR_ADDR[r*ADDR_W +: ADDR_W];
        localparam bit HAS_SET = (SA != '0);
        localparam bit HAS_CLR = (CA != '0);
        assign set_hit[r] = HAS_SET && (addr[MATCH_W-1:0] == SA[MATCH_W-1:0]);
        assign clr_hit[r] = HAS_CLR && (addr[MATCH_W-1:0] == CA[MATCH_W-1:0]);
        assign dual[r]    = HAS_SET && HAS_CLR;
    end

    // Descending scan: the lowest-indexed matching register wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        op  = WOP_NONE;
        for (int r = N_REGS - 1; r >= 0; r--) begin
            if (set_hit[r]) begin
                hit = 1'b1;
                idx = IDX_W'(r);
                op  = dual[r] ? WOP_SET : WOP_DIRECT;
            end else if (clr_hit[r]) begin
                hit = 1'b1;
                idx = IDX_W'(r);
                op  = WOP_CLR;
            end
        end
    end

endmodule

// File: rtl/mbank_update.sv
module mbank_update
    import mbank_pkg::*;
#(
    parameter int unsigned REG_W = 8
) (
    input  wop_e             op,
    input  logic [REG_W-1:0] cur,
    input  logic [REG_W-1:0] data,
    output logic [REG_W-1:0] nxt
);

    always_comb begin
        case (op)
            WOP_SET:    nxt = cur | data;
            WOP_CLR:    nxt = cur & ~data;
            WOP_DIRECT: nxt = data;
            default:    nxt = cur;
        endcase
    end

endmodule

// File: rtl/mbank_fields.sv
module mbank_fields #(
    parameter int unsigned REG_W = 8,
    parameter int unsigned SRC_W = 5,
    parameter int unsigned FLD_W = 1,
    parameter logic [REG_W*SRC_W-1:0] MAP = '0,
    localparam int unsigned NFLD = REG_W / FLD_W
) (
    input  logic [REG_W-1:0]       old_v,
    input  logic [REG_W-1:0]       new_v,
    output logic [REG_W-1:0]       ev_vld,
    output logic [REG_W-1:0]       ev_en,
    output logic [REG_W*SRC_W-1:0] ev_src
);

    for (genvar k = 0; k < REG_W; k++) begin : g_lane
        if (k < NFLD) begin : g_used
            localparam int unsigned LSB = REG_W - (k + 1) * FLD_W;
            localparam logic [SRC_W-1:0] ID = MAP[k*SRC_W +: SRC_W];
            logic [FLD_W-1:0] fo;
            logic [FLD_W-1:0] fn;
            assign fo = old_v[LSB +: FLD_W];
            assign fn = new_v[LSB +: FLD_W];
            assign ev_vld[k] = (fo != fn) && (ID != '0);
            assign ev_en[k]  = |fn;
            assign ev_src[k*SRC_W +: SRC_W] = ID;
        end else begin : g_idle
            assign ev_vld[k] = 1'b0;
            assign ev_en[k]  = 1'b0;
            assign ev_src[k*SRC_W +: SRC_W] = '0;
        end
    end

endmodule

// File: rtl/mbank_top.sv
module mbank_top
    import mbank_pkg::*;
#(
    parameter int unsigned N_REGS = BANK_REGS,
    parameter int unsigned REG_W  = BANK_REG_W,
    parameter int unsigned SRC_W  = BANK_SRC_W,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter logic [N_REGS*ADDR_W-1:0] SET_ADDR =
        {32'h0000_0118, 32'h0000_0110, 32'h0000_0108, 32'h0000_0100},
    parameter logic [N_REGS*ADDR_W-1:0] CLR_ADDR =
        {32'h0000_011C, 32'h0000_0000, 32'h0000_010C, 32'h0000_0104},
    parameter logic [N_REGS*8-1:0] FIELD_W_VEC = {8'd2, 8'd4, 8'd1, 8'd1},
    parameter logic [N_REGS*REG_W*SRC_W-1:0] SRC_MAP = default_map(),
    localparam int unsigned IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rdata,
    output logic [REG_W-1:0]       ev_vld,
    output logic [REG_W-1:0]       ev_en,
    output logic [REG_W*SRC_W-1:0] ev_src
);

    typedef struct packed {
        logic [N_REGS-1:0][REG_W-1:0] bank;
        logic [DATA_W-1:0]            rdata;
        logic [REG_W-1:0]             ev_vld;
        logic [REG_W-1:0]             ev_en;
        logic [REG_W*SRC_W-1:0]       ev_src;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic             hit;
    logic [IDX_W-1:0] idx;
    wop_e             op;
    logic [REG_W-1:0] upd_nxt;
    logic             unused_wd;

    logic [N_REGS-1:0][REG_W-1:0]       lane_vld;
    logic [N_REGS-1:0][REG_W-1:0]       lane_en;
    logic [N_REGS-1:0][REG_W*SRC_W-1:0] lane_src;
    logic [N_REGS*REG_W-1:0]            bank_flat;

    assign unused_wd = ^wdata[DATA_W-1:REG_W];

    mbank_decode #(
        .N_REGS  (N_REGS),
        .ADDR_W  (ADDR_W),
        .MATCH_W (29),
        .SET_ADDR(SET_ADDR),
        .CLR_ADDR(CLR_ADDR)
    ) u_dec (
        .addr(addr),
        .hit (hit),
        .idx (idx),
        .op  (op)
    );

    mbank_update #(
        .REG_W(REG_W)
    ) u_upd (
        .op  (op),
        .cur (st_q.bank[idx]),
        .data(wdata[REG_W-1:0]),
        .nxt (upd_nxt)
    );

    for (genvar r = 0; r < N_REGS; r++) begin : g_reg
        logic [REG_W-1:0] cand;
        assign cand = (wr_en && hit && (idx == IDX_W'(r))) ? upd_nxt : st_q.bank[r];

        mbank_fields #(
            .REG_W(REG_W),
            .SRC_W(SRC_W),
            .FLD_W(int'(FIELD_W_VEC[r*8 +: 8])),
            .MAP  (SRC_MAP[r*REG_W*SRC_W +: REG_W*SRC_W])
        ) u_fld (
            .old_v (st_q.bank[r]),
            .new_v (cand),
            .ev_vld(lane_vld[r]),
            .ev_en (lane_en[r]),
            .ev_src(lane_src[r])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.ev_vld = '0;
        st_d.ev_en  = '0;
        st_d.ev_src = '0;
        if (wr_en && hit) begin
            st_d.bank[idx] = upd_nxt;
            st_d.ev_vld    = lane_vld[idx];
            st_d.ev_en     = lane_en[idx];
            st_d.ev_src    = lane_src[idx];
        end
        if (rd_en) begin
            st_d.rdata = hit ? DATA_W'(st_q.bank[idx]) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_flat = st_q.bank;
    assign rdata     = st_q.rdata;
    assign ev_vld    = st_q.ev_vld;
    assign ev_en     = st_q.ev_en;
    assign ev_src    = st_q.ev_src;

endmodule

// File: rtl/mbank_checker.sv
module mbank_checker #(
    parameter int unsigned N_REGS = 4,
    parameter int unsigned REG_W  = 8,
    parameter int unsigned SRC_W  = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [REG_W-1:0]       ev_vld,
    input logic [REG_W*SRC_W-1:0] ev_src,
    input logic [N_REGS*REG_W-1:0] bank_flat
);

    p_bank_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank_flat));

    p_strobe_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_vld) |-> $past(wr_en));

    p_strobe_means_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_vld) |-> (bank_flat != $past(bank_flat)));

    for (genvar k = 0; k < REG_W; k++) begin : g_lane
        p_no_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ev_vld[k] |-> (ev_src[k*SRC_W +: SRC_W] != '0));
    end

endmodule

bind mbank_top mbank_checker #(
    .N_REGS(N_REGS),
    .REG_W (REG_W),
    .SRC_W (SRC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .ev_vld   (ev_vld),
    .ev_src   (ev_src),
    .bank_flat(bank_flat)
);

// File: tb/mbank_top_test.sv
module mbank_top_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic        rd_en;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [7:0]  ev_vld;
    logic [7:0]  ev_en;
    logic [39:0] ev_src;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;
    logic [7:0] model [4];

    always #10 clk = ~clk;

    mbank_top uut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .ev_vld(ev_vld),
        .ev_en (ev_en),
        .ev_src(ev_src)
    );

    function automatic logic [31:0] set_a(int r);
        return 32'h100 + 32'(r * 8);
    endfunction

    function automatic logic [31:0] clr_a(int r);
        return (r == 2) ? 32'h0 : 32'h104 + 32'(r * 8);
    endfunction

    function automatic int fw(int r);
        return (r < 2) ? 1 : (r == 2) ? 4 : 2;
    endfunction

    function automatic int src_id(int r, int k);
        int id;
        id = r * 8 + k;
        return (id % 7 == 0) ? 0 : id;
    endfunction

    task automatic do_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 32'h0; wdata = 32'h0;
    endtask

    task automatic check_read(input logic [31:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0; addr = 32'h0;
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s read addr %h got %h exp %h", tag, a, rdata, exp);
        end
    endtask

    // Expected strobes computed from the field layout (R7, R8, R9).
    task automatic check_events(input int r, input logic [7:0] oldv, input logic [7:0] newv,
                                input string tag);
        logic [7:0]  exp_v;
        logic [7:0]  exp_e;
        logic [39:0] exp_s;
        logic [7:0]  got_e;
        logic [39:0] got_s;
        int n;
        int m;
        exp_v = '0; exp_e = '0; exp_s = '0; got_e = '0; got_s = '0;
        n = 8 / fw(r);
        m = (1 << fw(r)) - 1;
        for (int k = 0; k < n; k++) begin
            int sh;
            int of;
            int nf;
            int id;
            sh = 8 - (k + 1) * fw(r);
            of = (int'(oldv) >> sh) & m;
            nf = (int'(newv) >> sh) & m;
            id = src_id(r, k);
            if (of != nf && id != 0) begin
                exp_v[k] = 1'b1;
                exp_e[k] = (nf != 0);
                exp_s[k*5 +: 5] = 5'(id);
            end
        end
        for (int k = 0; k < 8; k++) begin
            if (ev_vld[k]) begin
                got_e[k] = ev_en[k];
                got_s[k*5 +: 5] = ev_src[k*5 +: 5];
            end
        end
        checks++;
        if (ev_vld !== exp_v || got_e !== exp_e || got_s !== exp_s) begin
            errors++;
            $display("FAIL %s reg %0d old %h new %h: vld/en/src got %h/%h/%h exp %h/%h/%h",
                     tag, r, oldv, newv, ev_vld, got_e, got_s, exp_v, exp_e, exp_s);
        end
    endtask

    task automatic check_idle(input string tag);
        @(negedge clk);
        checks++;
        if (ev_vld !== 8'h0) begin
            errors++;
            $display("FAIL %s strobe held: got %h exp 00", tag, ev_vld);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        for (int r = 0; r < 4; r++) model[r] = 8'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        checks++;
        if (ev_vld !== 8'h0 || rdata !== 32'h0) begin
            errors++;
            $display("FAIL R11 after reset vld/rdata got %h/%h exp 00/00000000", ev_vld, rdata);
        end
        for (int r = 0; r < 4; r++) check_read(set_a(r), 32'h0, "R11");

        // R2 R3 R4 R7 R8 R9: sweep every data value through each alias
        for (int r = 0; r < 4; r++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0]  oldv;
                logic [7:0]  d;
                logic [31:0] hi;
                hi = v[0] ? 32'hE000_0000 : 32'h0;  // R1 alias bits
                if (r == 2) begin
                    oldv = model[r];
                    model[r] = 8'(v);
                    do_write(set_a(r) | hi, 32'hFFFF_FF00 | 32'(v));
                    check_events(r, oldv, model[r], "R4 R7 R8 R9 R1");
                end else begin
                    oldv = model[r];
                    model[r] = model[r] | 8'(v);
                    do_write(set_a(r) | hi, 32'(v));
                    check_events(r, oldv, model[r], "R2 R7 R8 R9 R1");
                    d = 8'((v * 37 + 11) & 255);
                    oldv = model[r];
                    model[r] = model[r] & ~d;
                    do_write(clr_a(r) | hi, 32'hAB00_0000 | 32'(d));
                    check_events(r, oldv, model[r], "R3 R7 R8 R9 R1");
                end
                if (v % 32 == 0) begin
                    check_read(set_a(r), 32'(model[r]), "R5 R2 R3 R4");
                    if (r != 2) check_read(clr_a(r) | 32'h2000_0000, 32'(model[r]), "R5 R1");
                end
            end
        end

        // R10: strobe lasts one cycle
        begin
            logic [7:0] oldv;
            oldv = model[3];
            model[3] = model[3] ^ 8'hFF;
            do_write(set_a(3), 32'hFF);
            model[3] = oldv | 8'hFF;
            check_events(3, oldv, model[3], "R10 R8");
            check_idle("R10");
        end

        // R6: unmapped writes ignored, unmapped reads zero
        do_write(32'h120, 32'hFF);
        check_events(0, model[0], model[0], "R6");
        do_write(32'h0, 32'hFF);
        check_events(0, model[0], model[0], "R6");
        do_write(32'h114, 32'hFF);
        check_events(0, model[0], model[0], "R6");
        check_read(32'h120, 32'h0, "R5");
        check_read(32'h0, 32'h0, "R5");
        for (int r = 0; r < 4; r++) check_read(set_a(r), 32'(model[r]), "R6");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule